// File: doc/BRIEF.md
# Four-Stage Shift Register with Set/Clear/Toggle First Stage

This block is a small clocked register chain that moves data toward its last stage one position per rising clock edge, or captures a full parallel word in one edge. An active-low mode input selects between the two. While shifting, the first stage does not simply copy a serial input. It takes its next value from a two-input control pair: a high-active `jIn` and a low-active `kInN`. With these two inputs the first stage can be forced high, forced low, inverted or left as it is. When the two control inputs are wired together they behave as one plain serial data input.

The block is used for serial-to-parallel conversion, for parallel-to-serial conversion, and as a counter-like element where the first stage feeds back on itself. An active-low asynchronous reset clears every stage at once. The outputs are the stage values plus a complement of the final stage. The chain length is a parameter and defaults to four.

Top module: `jkShiftReg`

## Requirements
- R1: While `rstN` is low, every bit of `stageOut` is 0 and `lastInvOut` is 1. This takes effect without waiting for a clock edge and holds over any clock edge and any input values. After `rstN` rises, the outputs stay at zero until the next rising edge.
- R2: On a rising edge with `parEnN` low, `stageOut[i]` takes `parIn[i]` for every i. The values of `jIn` and `kInN` have no effect on the result.
- R3: On a rising edge with `parEnN` high, `stageOut[i]` takes the old `stageOut[i-1]` for every i from 1 to the last stage.
- R4: On a rising edge with `parEnN` high, `jIn`=1 and `kInN`=1, `stageOut[0]` becomes 1.
- R5: On a rising edge with `parEnN` high, `jIn`=0 and `kInN`=0, `stageOut[0]` becomes 0.
- R6: On a rising edge with `parEnN` high, `jIn`=1 and `kInN`=0, `stageOut[0]` becomes the inverse of its previous value.
- R7: On a rising edge with `parEnN` high, `jIn`=0 and `kInN`=1, `stageOut[0]` keeps its previous value.
- R8: `lastInvOut` always equals the inverse of the last bit of `stageOut`.
- R9: With `jIn` and `kInN` driven by the same signal in shift mode, `stageOut[0]` takes that signal's value on each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers occur on the rising edge |
| rstN | input | 1 | Asynchronous clear, active low |
| parEnN | input | 1 | Mode select: low loads `parIn`, high shifts |
| jIn | input | 1 | First-stage set control, active high |
| kInN | input | 1 | First-stage clear control, active low |
| parIn | input | STAGES (4) | Parallel word; bit i goes to stage i |
| stageOut | output | STAGES (4) | Current stage values; bit 0 is the first stage |
| lastInvOut | output | 1 | Complement of the last stage |

## Verification
Every stage drives a port, so a wrong stage value appears on `stageOut` directly after the edge that produced it. The bench compares all outputs after every edge, which means a fault is caught in the same cycle it occurs. A wrong first-stage decision also travels down the chain and reaches `lastInvOut` one edge per stage later. This gives the toggle and hold cases a second look through the complement output. A reset that fails to act asynchronously shows up as nonzero outputs in the middle of a cycle, before any edge arrives.

// File: rtl/jkShiftPkg.sv
package jkShiftPkg;

  // Action applied to the first stage in shift mode, coded as {jIn, kInN}
  typedef enum logic [1:0] {
    FIRST_CLEAR  = 2'b00,
    FIRST_HOLD   = 2'b01,
    FIRST_TOGGLE = 2'b10,
    FIRST_SET    = 2'b11
  } firstOpE;

  typedef struct packed {
    logic    loadEn;   // capture parallel word this edge
    firstOpE firstOp;  // first-stage action when shifting
  } ctrlStrobesS;

endpackage

// File: rtl/jkShiftCtrl.sv
module jkShiftCtrl
  import jkShiftPkg::*;
(
  input  logic        parEnN,
  input  logic        jIn,
  input  logic        kInN,
  output ctrlStrobesS strobes
);

  always_comb begin
    strobes.loadEn = ~parEnN;
    unique case ({jIn, kInN})
      2'b11:   strobes.firstOp = FIRST_SET;
      2'b00:   strobes.firstOp = FIRST_CLEAR;
      2'b10:   strobes.firstOp = FIRST_TOGGLE;
      default: strobes.firstOp = FIRST_HOLD;
    endcase
  end

endmodule

// File: rtl/jkShiftPath.sv
module jkShiftPath
  import jkShiftPkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesS       strobes,
  input  logic [STAGES-1:0] parIn,
  output logic [STAGES-1:0] stageQ,
  output logic              lastInv
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stageD;
  logic              firstNext;

  always_comb begin
    unique case (strobes.firstOp)
      FIRST_SET:    firstNext = 1'b1;
      FIRST_CLEAR:  firstNext = 1'b0;
      FIRST_TOGGLE: firstNext = ~stageQ[0];
      default:      firstNext = stageQ[0];
    endcase
  end

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    if (i == 0) begin : gFirst
      assign stageD[i] = strobes.loadEn ? parIn[i] : firstNext;
    end else begin : gRest
      assign stageD[i] = strobes.loadEn ? parIn[i] : stageQ[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= stageD;
  end

  assign lastInv = ~stageQ[LAST];

endmodule

// File: rtl/jkShiftReg.sv
module jkShiftReg
  import jkShiftPkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parEnN,
  input  logic              jIn,
  input  logic              kInN,
  input  logic [STAGES-1:0] parIn,
  output logic [STAGES-1:0] stageOut,
  output logic              lastInvOut
);

  ctrlStrobesS strobes;

  jkShiftCtrl uCtrl (
    .parEnN (parEnN),
    .jIn    (jIn),
    .kInN   (kInN),
    .strobes(strobes)
  );

  jkShiftPath #(.STAGES(STAGES)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .parIn  (parIn),
    .stageQ (stageOut),
    .lastInv(lastInvOut)
  );

endmodule

// File: rtl/jkShiftReg_chk.sv
module jkShiftReg_chk #(
  parameter int STAGES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              parEnN,
  input logic              jIn,
  input logic              kInN,
  input logic [STAGES-1:0] parIn,
  input logic [STAGES-1:0] stageOut,
  input logic              lastInvOut
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |-> (stageOut == '0 && lastInvOut)); // R1

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rstN)
    !parEnN |=> stageOut == $past(parIn)); // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    parEnN |=> stageOut[STAGES-1:1] == $past(stageOut[STAGES-2:0])); // R3

  AST_FIRST_SET: assert property (@(posedge clk) disable iff (!rstN)
    (parEnN && jIn && kInN) |=> stageOut[0]); // R4

  AST_FIRST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (parEnN && !jIn && !kInN) |=> !stageOut[0]); // R5

  AST_FIRST_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (parEnN && jIn && !kInN) |=> stageOut[0] != $past(stageOut[0])); // R6

  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (parEnN && !jIn && kInN) |=> $stable(stageOut[0])); // R7

  AST_LAST_INVERSE: assert property (@(posedge clk)
    lastInvOut != stageOut[STAGES-1]); // R8

endmodule

bind jkShiftReg jkShiftReg_chk #(.STAGES(STAGES)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .parEnN    (parEnN),
  .jIn       (jIn),
  .kInN      (kInN),
  .parIn     (parIn),
  .stageOut  (stageOut),
  .lastInvOut(lastInvOut)
);

// File: tb/tb_jkShiftReg.sv
`timescale 1ns/1ps
module tb_jkShiftReg;

  localparam int STAGES = 4;
  localparam real HALF = 4.0; // 8 ns period, 125 MHz

  logic              clk = 1'b0;
  logic              rstN;
  logic              parEnN;
  logic              jIn;
  logic              kInN;
  logic [STAGES-1:0] parIn;
  logic [STAGES-1:0] stageOut;
  logic              lastInvOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  jkShiftReg #(.STAGES(STAGES)) dut (
    .clk       (clk),
    .rstN      (rstN),
    .parEnN    (parEnN),
    .jIn       (jIn),
    .kInN      (kInN),
    .parIn     (parIn),
    .stageOut  (stageOut),
    .lastInvOut(lastInvOut)
  );

  // {parEnN, jIn, kInN, parIn[3:0], expected stageOut[3:0]}, starting from all zeros
  localparam int NVEC = 15;
  localparam logic [10:0] VEC [NVEC] = '{
    {3'b011, 4'b1010, 4'b1010}, // R2 load, J/K ignored
    {3'b111, 4'b0000, 4'b0101}, // R4 set
    {3'b100, 4'b1111, 4'b1010}, // R5 clear
    {3'b110, 4'b0000, 4'b0101}, // R6 toggle 0->1
    {3'b110, 4'b0000, 4'b1010}, // R6 toggle 1->0
    {3'b101, 4'b0000, 4'b0100}, // R7 hold 0
    {3'b101, 4'b1111, 4'b1000}, // R7 hold 0
    {3'b111, 4'b0000, 4'b0001}, // R4 set
    {3'b101, 4'b0000, 4'b0011}, // R7 hold 1
    {3'b000, 4'b0110, 4'b0110}, // R2 load
    {3'b110, 4'b0000, 4'b1101}, // R6 toggle
    {3'b010, 4'b1111, 4'b1111}, // R2 load all ones
    {3'b100, 4'b0000, 4'b1110}, // R5 clear
    {3'b111, 4'b0000, 4'b1101}, // R9 tied high
    {3'b100, 4'b0000, 4'b1010}  // R9 tied low
  };

  task automatic checkOut(input string req, input logic [STAGES-1:0] exp);
    checks++;
    if (stageOut !== exp) begin
      errors++;
      $display("FAIL %s stageOut actual=%b expected=%b", req, stageOut, exp);
    end
    checks++;
    if (lastInvOut !== ~exp[STAGES-1]) begin
      errors++;
      $display("FAIL R8 (%s) lastInvOut actual=%b expected=%b", req, lastInvOut, ~exp[STAGES-1]);
    end
  endtask

  task automatic applyEdge(input logic pe, input logic j, input logic k,
                           input logic [STAGES-1:0] d);
    @(negedge clk);
    parEnN = pe; jIn = j; kInN = k; parIn = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rstN = 1'b0; parEnN = 1'b1; jIn = 1'b0; kInN = 1'b1; parIn = '0;
    #1;
    checkOut("R1 reset at start", '0);
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    checkOut("R1 after release", '0);

    for (int v = 0; v < NVEC; v++) begin
      applyEdge(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:4]);
      checkOut($sformatf("R2-R7/R9 vector %0d", v), VEC[v][3:0]);
    end

    // reset asserted mid-cycle during a shift sequence
    applyEdge(1'b1, 1'b1, 1'b1, '0); // 1010 -> 0101
    checkOut("R4 before reset", 4'b0101);
    @(negedge clk);
    #1 rstN = 1'b0;
    #1;
    checkOut("R1 async clear mid-cycle", '0);
    parEnN = 1'b0; parIn = 4'b1111;
    @(posedge clk);
    #1;
    checkOut("R1 load blocked by reset", '0);
    @(negedge clk) rstN = 1'b1;
    parEnN = 1'b1; jIn = 1'b1; kInN = 1'b1;
    #1;
    checkOut("R1 zeros until edge", '0);
    @(posedge clk);
    #1;
    checkOut("R4 set after reset", 4'b0001);
    applyEdge(1'b1, 1'b1, 1'b0, '0); // toggle 1 -> 0, shift
    checkOut("R6 toggle after reset", 4'b0010);
    applyEdge(1'b1, 1'b0, 1'b1, '0);
    checkOut("R3 shift toward last", 4'b0100);
    applyEdge(1'b1, 1'b0, 1'b1, '0);
    checkOut("R3 reaches last stage", 4'b1000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(HALF * 2 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule